// File: doc/BRIEF.md
# Serial Programming Port with Latch Routing

This block receives configuration words over a three-wire serial link: a bit clock, a data line and a load strobe. All three wires are asynchronous to the system clock. Each rising edge of the bit clock moves one data bit into a 24-bit shift register, with the most significant bit sent first. A rising edge of the load strobe copies the shift register into one of four holding latches. The two lowest bits of the word itself select the latch.

The four targets are a reference divider latch, a main divider latch (split into a small and a large count), a function latch, and an initialization target. A write to the initialization target also loads the function latch and raises a counter-reset output for one cycle. Logic downstream reads the latched counts and fields directly from the parallel outputs.

The three wires pass through a synchronizer into the system clock domain. There they are edge-detected, so each wire transition acts exactly once.

Top module: `ser_prog_port`

## Requirements
- R1: After reset, `ref_count`, `a_count`, `b_count` and `func_word` are all zero and `cnt_rst` is low.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into the LSB of a 24-bit register. The bits already held move toward the MSB. Only the last 24 bits shifted before a load count, with the first of those 24 bits landing in bit 23.
- R3: On a load with word bits [1:0] = 00, `ref_count` takes word bits [15:2].
- R4: On a load with word bits [1:0] = 01, `a_count` takes word bits [7:2] and `b_count` takes word bits [20:8].
- R5: On a load with word bits [1:0] = 10, `func_word` takes word bits [23:2] and `cnt_rst` stays low.
- R6: On a load with word bits [1:0] = 11, `func_word` takes word bits [23:2]. `cnt_rst` is high for exactly one system clock cycle.
- R7: A latch that the load does not select keeps its value.
- R8: Each rising edge of `ser_load` causes exactly one load. Holding `ser_load` high, or shifting bits while it is high, loads nothing more.
- R9: If a load edge and a shift edge are detected in the same system cycle, the load takes the contents as they were before that shift. The shift still takes place.
- R10: Falling edges of `ser_clk` shift nothing, even when `ser_data` has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; its rising edge routes the word to a latch |
| ref_count | output | 14 | Reference divider count |
| a_count | output | 6 | Small main-divider count |
| b_count | output | 13 | Large main-divider count |
| func_word | output | 22 | Function latch contents (word bits 23..2) |
| cnt_rst | output | 1 | One-cycle counter reset, raised on an initialization write |

## Verification
A shift and a load can fall in the same system cycle. The bench provokes this by raising the bit clock and the load strobe in the same half-period, so both pass through synchronizers of equal depth together. It checks that the routed word is the one held before that final bit arrived. It then issues a second, clean load and checks that the latched word includes the extra bit. The bench predicts both results arithmetically from the words it sent.

// File: rtl/ser_prog_pkg.sv
package ser_prog_pkg;
  localparam int WORD_W   = 24;
  localparam int SEL_W    = 2;
  localparam int REF_W    = 14;
  localparam int REF_LSB  = 2;
  localparam int ACNT_W   = 6;
  localparam int ACNT_LSB = 2;
  localparam int BCNT_W   = 13;
  localparam int BCNT_LSB = 8;
  localparam int FUNC_W   = WORD_W - SEL_W;

  typedef enum logic [1:0] {
    SEL_REF  = 2'b00,
    SEL_NCNT = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } latch_sel_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WORD_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/ser_latch_bank.sv
module ser_latch_bank
  import ser_prog_pkg::*;
#(
  parameter int WORD_W   = ser_prog_pkg::WORD_W,
  parameter int SEL_W    = ser_prog_pkg::SEL_W,
  parameter int REF_W    = ser_prog_pkg::REF_W,
  parameter int REF_LSB  = ser_prog_pkg::REF_LSB,
  parameter int ACNT_W   = ser_prog_pkg::ACNT_W,
  parameter int ACNT_LSB = ser_prog_pkg::ACNT_LSB,
  parameter int BCNT_W   = ser_prog_pkg::BCNT_W,
  parameter int BCNT_LSB = ser_prog_pkg::BCNT_LSB,
  localparam int FUNC_W  = WORD_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word,
  output logic [REF_W-1:0]  ref_count,
  output logic [ACNT_W-1:0] a_count,
  output logic [BCNT_W-1:0] b_count,
  output logic [FUNC_W-1:0] func_word,
  output logic              cnt_rst
);
  logic [REF_W-1:0]  ref_q,  ref_d;
  logic [ACNT_W-1:0] a_q,    a_d;
  logic [BCNT_W-1:0] b_q,    b_d;
  logic [FUNC_W-1:0] func_q, func_d;
  logic              rst_q,  rst_d;
  latch_sel_e        sel;

  assign sel = latch_sel_e'(word[SEL_W-1:0]);

  always_comb begin
    ref_d  = ref_q;
    a_d    = a_q;
    b_d    = b_q;
    func_d = func_q;
    rst_d  = 1'b0;
    if (load_en) begin
      case (sel)
        SEL_REF:  ref_d = word[REF_LSB +: REF_W];
        SEL_NCNT: begin
          a_d = word[ACNT_LSB +: ACNT_W];
          b_d = word[BCNT_LSB +: BCNT_W];
        end
        SEL_FUNC: func_d = word[WORD_W-1:SEL_W];
        SEL_INIT: begin
          func_d = word[WORD_W-1:SEL_W];
          rst_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      func_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      a_q    <= a_d;
      b_q    <= b_d;
      func_q <= func_d;
      rst_q  <= rst_d;
    end
  end

  assign ref_count = ref_q;
  assign a_count   = a_q;
  assign b_count   = b_q;
  assign func_word = func_q;
  assign cnt_rst   = rst_q;
endmodule

// File: rtl/ser_prog_port.sv
module ser_prog_port
  import ser_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = ser_prog_pkg::WORD_W,
  parameter int REF_W       = ser_prog_pkg::REF_W,
  parameter int ACNT_W      = ser_prog_pkg::ACNT_W,
  parameter int BCNT_W      = ser_prog_pkg::BCNT_W,
  localparam int FUNC_W     = WORD_W - ser_prog_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [REF_W-1:0]  ref_count,
  output logic [ACNT_W-1:0] a_count,
  output logic [BCNT_W-1:0] b_count,
  output logic [FUNC_W-1:0] func_word,
  output logic              cnt_rst
);
  localparam int LINE_DATA = 0;
  localparam int LINE_CLK  = 1;
  localparam int LINE_LOAD = 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [2:0]        line_lvl;
  logic [1:0]        prev_q, prev_d;
  logic              shift_stb;
  logic              load_stb;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  ser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   ({ser_load, ser_clk, ser_data}),
    .dout  (line_lvl)
  );

  always_comb begin
    prev_d = {line_lvl[LINE_LOAD], line_lvl[LINE_CLK]};
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) prev_q <= 2'b00;
    else            prev_q <= prev_d;
  end

  assign shift_stb = line_lvl[LINE_CLK]  & ~prev_q[0];
  assign load_stb  = line_lvl[LINE_LOAD] & ~prev_q[1];

  ser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .shift_en (shift_stb),
    .bit_in   (line_lvl[LINE_DATA]),
    .word     (word_q)
  );

  ser_latch_bank #(
    .WORD_W (WORD_W),
    .REF_W  (REF_W),
    .ACNT_W (ACNT_W),
    .BCNT_W (BCNT_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_en   (load_stb),
    .word      (word_q),
    .ref_count (ref_count),
    .a_count   (a_count),
    .b_count   (b_count),
    .func_word (func_word),
    .cnt_rst   (cnt_rst)
  );
endmodule

// File: rtl/ser_prog_chk.sv
module ser_prog_chk
  import ser_prog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              shift_stb,
  input logic              load_stb,
  input logic [WORD_W-1:0] word_q,
  input logic [REF_W-1:0]  ref_count,
  input logic [ACNT_W-1:0] a_count,
  input logic [BCNT_W-1:0] b_count,
  input logic [FUNC_W-1:0] func_word,
  input logic              cnt_rst
);
  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |=> word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0]));

  assert_ref_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && word_q[1:0] == 2'b00) |=> ref_count == $past(word_q[REF_LSB +: REF_W]));

  assert_ncnt_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && word_q[1:0] == 2'b01) |=>
      (a_count == $past(word_q[ACNT_LSB +: ACNT_W])) && (b_count == $past(word_q[BCNT_LSB +: BCNT_W])));

  assert_func_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && word_q[1]) |=> func_word == $past(word_q[WORD_W-1:SEL_W]));

  assert_rst_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> $past(load_stb && word_q[1:0] == 2'b11));

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !cnt_rst);

  assert_ref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_stb && word_q[1:0] == 2'b00) |=> $stable(ref_count));

  assert_ncnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_stb && word_q[1:0] == 2'b01) |=> ($stable(a_count) && $stable(b_count)));

  assert_func_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_stb && word_q[1]) |=> $stable(func_word));

  assert_single_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
endmodule

bind ser_prog_port ser_prog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .shift_stb (shift_stb),
  .load_stb  (load_stb),
  .word_q    (word_q),
  .ref_count (ref_count),
  .a_count   (a_count),
  .b_count   (b_count),
  .func_word (func_word),
  .cnt_rst   (cnt_rst)
);

// File: tb/sim_ser_prog_port.sv
module sim_ser_prog_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, ser_clk, ser_data, ser_load;
  logic [13:0] ref_count;
  logic [5:0]  a_count;
  logic [12:0] b_count;
  logic [21:0] func_word;
  logic        cnt_rst;

  ser_prog_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .ref_count(ref_count), .a_count(a_count),
    .b_count(b_count), .func_word(func_word), .cnt_rst(cnt_rst)
  );

  int checks = 0;
  int fails  = 0;
  int rst_seen = 0;
  int exp_rst = 0;
  bit done = 1'b0;
  logic [13:0] e_ref;
  logic [5:0]  e_a;
  logic [12:0] e_b;
  logic [21:0] e_func;

  always @(negedge clk) if (rst_n && cnt_rst) rst_seen++;

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Data changes again while the bit clock is high, so a falling edge must not shift (R10).
  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      idle(3);
      ser_clk = 1'b1;
      idle(3);
      ser_data = ~v[i];
      idle(1);
      ser_clk = 1'b0;
      idle(3);
    end
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    idle(4);
    ser_load = 1'b0;
    idle(6);
  endtask

  task automatic model(logic [23:0] w);
    case (w[1:0])
      2'b00: e_ref = w[15:2];
      2'b01: begin e_a = w[7:2]; e_b = w[20:8]; end
      2'b10: e_func = w[23:2];
      default: begin e_func = w[23:2]; exp_rst++; end
    endcase
  endtask

  task automatic check_all(string req);
    chk({req, " ref_count"}, 32'(ref_count), 32'(e_ref));
    chk({req, " a_count"},   32'(a_count),   32'(e_a));
    chk({req, " b_count"},   32'(b_count),   32'(e_b));
    chk({req, " func_word"}, 32'(func_word), 32'(e_func));
    chk({req, " cnt_rst pulses"}, 32'(rst_seen), 32'(exp_rst));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] w, w2;
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    e_ref = '0; e_a = '0; e_b = '0; e_func = '0;
    idle(5);
    rst_n = 1'b1;
    idle(10);
    check_all("R1");

    // Sweep: every address with several patterns; unselected latches must hold (R7).
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 6; k++) begin
        if (k == 0)      w = 24'h000000;
        else if (k == 1) w = 24'hFFFFFF;
        else             w = 24'(((k * 32'h9E3779B1) ^ (a * 32'h0005A5A5)) >> 5);
        w[1:0] = 2'(a);
        shift_bits({8'h00, w}, 24);
        pulse_load();
        model(w);
        case (a)
          0: check_all("R3 R7 R10");
          1: check_all("R4 R7 R10");
          2: check_all("R5 R7");
          default: check_all("R6 R7");
        endcase
      end
    end

    // R2: six leading bits must drop out of the 24-bit window.
    w = 24'hC3A5_5D;
    w[1:0] = 2'b00;
    shift_bits({2'b00, 6'b101101, w}, 30);
    pulse_load();
    model(w);
    check_all("R2");

    // R8: load held high gives one init pulse; shifting under a high load loads nothing.
    w = 24'h5A0F_37;
    shift_bits({8'h00, w}, 24);
    ser_load = 1'b1;
    idle(20);
    model(w);
    check_all("R8 R6 held");
    w2 = 24'h81E2_D1;
    shift_bits({8'h00, w2}, 24);
    ser_load = 1'b0;
    idle(6);
    check_all("R8 no extra load");
    pulse_load();
    model(w2);
    check_all("R8 next edge");

    // R9: shift and load edges in the same cycle; load sees the pre-shift word.
    w = 24'h9B64_2C;
    shift_bits({8'h00, w}, 24);
    ser_data = 1'b1;
    ser_clk  = 1'b1;
    ser_load = 1'b1;
    idle(6);
    ser_clk  = 1'b0;
    ser_load = 1'b0;
    idle(6);
    model(w);
    check_all("R9 collision");
    w2 = {w[22:0], 1'b1};
    pulse_load();
    model(w2);
    check_all("R9 shifted bit kept");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule